// File: doc/BRIEF.md
# Synchronous Pipelined Burst SRAM

This block is a synthesizable, cycle-level model of a single-clock synchronous static RAM. Address, write data and every control input are captured at the rising clock edge. Two exceptions act at once: the output enable and the sleep input. Reads are pipelined through an output register. Writes are byte-granular: each lane is 9 bits wide, made up of 8 data bits and one parity bit. The bidirectional data bus is modelled as a data-in bus, a data-out bus and a drive-enable flag. When the flag is low, the bus is taken to be in high impedance.

Each cycle's type is decided by two competing address strobes: one for the processor side and one for the controller side. Three chip enables and a burst advance input also take part. A strobe cycle loads an external address and starts a 4-beat burst. Later cycles with both strobes high either step to the next address in the burst or hold the current address as a wait state. A separate sequencing block makes the step order. In linear order the low two address bits count upward from the start address and wrap. In interleaved order the low two bits are the start address XORed with the beat number.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, the drive-enable flag `dq_drive` is low and no burst is active. A continue or wait cycle (both strobes high, chip select 1 low) with no active burst performs no read, performs no write and drives nothing.
- R2: A cycle is a deselect in either of two cases:
  - `cs1_n` is high and `strb_ctl_n` is low;
  - `cs1_n` is low, one of the strobes is low, and either `cs2` is low or `cs3_n` is high.

  A deselect ends the active burst. From the second rising edge after the deselect, `dq_drive` stays low until a new read.
- R3: While `cs1_n` is high, `strb_proc_n` is ignored. With `strb_ctl_n` high, that cycle continues or suspends the active burst.
- R4: A cycle with `strb_proc_n` low and all enables active (`cs1_n`=0, `cs2`=1, `cs3_n`=0) starts a read burst at `addr`, whatever the write controls are.
- R5: A cycle with `strb_proc_n` high, `strb_ctl_n` low and all enables active starts a burst at `addr`. It is a write if the write signal of R8 is active, otherwise a read.
- R6: With both strobes high and `step_n` low, the burst steps to its next beat. The upper address bits stay fixed. The low two bits follow `order_sel`:
  - `order_sel`=0: start+beat modulo 4;
  - `order_sel`=1: start XOR beat.
- R7: With both strobes high and `step_n` high, the current address is used again (wait state).
- R8: The write signal is active when `wr_all_n` is low, or when `wr_lane_en_n` is low and at least one bit of `lane_wr_n` is low.
  - `wr_all_n` low writes every lane.
  - Otherwise, bit i of `lane_wr_n` low writes data bits [9i+8:9i].
  - `wr_lane_en_n` low with all `lane_wr_n` bits high is a read.
- R9: Read data of a cycle captured at edge k is on `dq_out`, with `dq_drive` high, after edge k+1.
- R10: `oe_n` acts at once. `dq_drive` is high only while `oe_n` is low and read data is valid.
- R11: While `sleep` is high, `dq_drive` is low at once. At an edge with `sleep` high, all other inputs are ignored: no write takes place and the burst state is kept.
- R12: A write stores the `dq_in` value presented in the same cycle as its controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address |
| cs1_n | input | 1 | Chip select 1, active low |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| strb_proc_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Low: step burst; high: wait state |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lane_en_n | input | 1 | Enables the per-lane write controls, active low |
| lane_wr_n | input | LANES | Per-lane write controls, active low |
| oe_n | input | 1 | Output enable, active low, immediate |
| sleep | input | 1 | Sleep, active high, immediate on output |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| dq_in | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Read data register |
| dq_drive | output | 1 | High when the data bus is driven |

## Verification
A read cycle is driven just after one edge and captured at the next edge. The bench samples `dq_out` and `dq_drive` 1 ns after the edge that follows that capture. Back-to-back burst beats are checked one beat behind the command being driven. Writes need no delay: their effect is checked by a later read burst against a reference array kept in the bench. The effects of `oe_n` and `sleep` are checked 1 ns after the input changes, between edges. For deselects, the bench checks that the old data stays driven for one more edge and is dropped after the second edge.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_DESEL,
        CYC_LOAD,
        CYC_STEP,
        CYC_WAIT
    } cyc_e;
endpackage

// File: rtl/sbsram_burst.sv
module sbsram_burst #(
    parameter int W = 2
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] beat,
    input  logic         interleave,
    output logic [W-1:0] lo
);
    always_comb begin
        if (interleave) lo = base ^ beat;
        else            lo = base + beat;
    end
endmodule

// File: rtl/sbsram_decode.sv
module sbsram_decode import sbsram_pkg::*; #(
    parameter int LANES = 2
) (
    input  logic             cs1_n,
    input  logic             cs2,
    input  logic             cs3_n,
    input  logic             strb_proc_n,
    input  logic             strb_ctl_n,
    input  logic             step_n,
    input  logic             wr_all_n,
    input  logic             wr_lane_en_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             sleep,
    output cyc_e             cyc,
    output logic             wr,
    output logic [LANES-1:0] mask
);
    logic en_ok;
    logic proc_hit;
    logic wr_sig;

    always_comb begin
        en_ok    = !cs1_n && cs2 && !cs3_n;
        proc_hit = !cs1_n && !strb_proc_n;
        wr_sig   = !wr_all_n || (!wr_lane_en_n && !(&lane_wr_n));
        if (!wr_all_n)         mask = '1;
        else if (!wr_lane_en_n) mask = ~lane_wr_n;
        else                    mask = '0;

        cyc = CYC_IDLE;
        wr  = 1'b0;
        if (sleep) begin
            cyc = CYC_IDLE;
        end else if (proc_hit) begin
            cyc = en_ok ? CYC_LOAD : CYC_DESEL;
        end else if (!strb_ctl_n) begin
            cyc = en_ok ? CYC_LOAD : CYC_DESEL;
            wr  = en_ok && wr_sig;
        end else begin
            cyc = step_n ? CYC_WAIT : CYC_STEP;
            wr  = wr_sig;
        end
    end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram import sbsram_pkg::*; #(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 2,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    strb_proc_n,
    input  logic                    strb_ctl_n,
    input  logic                    step_n,
    input  logic                    wr_all_n,
    input  logic                    wr_lane_en_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic                    order_sel,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_drive
);
    localparam int DW    = LANES * LANE_W;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int HI_W  = ADDR_W - BURST_W;

    typedef struct packed {
        logic               active;
        logic [BURST_W-1:0] beat;
        logic [BURST_W-1:0] base;
        logic [HI_W-1:0]    hi;
        logic               rd_valid;
        logic [ADDR_W-1:0]  rd_addr;
        logic               out_valid;
        logic [DW-1:0]      data;
    } st_t;

    st_t st_d, st_q;

    logic [DW-1:0] mem [DEPTH];

    cyc_e               cyc;
    logic               dec_wr;
    logic [LANES-1:0]   dec_mask;
    logic [BURST_W-1:0] seq_base, seq_beat, seq_lo;
    logic [HI_W-1:0]    seq_hi;
    logic               acc;
    logic [ADDR_W-1:0]  acc_addr;
    logic [LANES-1:0]   mem_we;

    sbsram_decode #(.LANES(LANES)) u_decode (
        .cs1_n        (cs1_n),
        .cs2          (cs2),
        .cs3_n        (cs3_n),
        .strb_proc_n  (strb_proc_n),
        .strb_ctl_n   (strb_ctl_n),
        .step_n       (step_n),
        .wr_all_n     (wr_all_n),
        .wr_lane_en_n (wr_lane_en_n),
        .lane_wr_n    (lane_wr_n),
        .sleep        (sleep),
        .cyc          (cyc),
        .wr           (dec_wr),
        .mask         (dec_mask)
    );

    // Choose burst start and beat for this cycle's access
    always_comb begin
        seq_base = st_q.base;
        seq_beat = st_q.beat;
        seq_hi   = st_q.hi;
        acc      = 1'b0;
        case (cyc)
            CYC_LOAD: begin
                seq_base = addr[BURST_W-1:0];
                seq_beat = '0;
                seq_hi   = addr[ADDR_W-1:BURST_W];
                acc      = 1'b1;
            end
            CYC_STEP: begin
                seq_beat = st_q.beat + 1'b1;
                acc      = st_q.active;
            end
            CYC_WAIT: acc = st_q.active;
            default:  acc = 1'b0;
        endcase
    end

    sbsram_burst #(.W(BURST_W)) u_burst (
        .base       (seq_base),
        .beat       (seq_beat),
        .interleave (order_sel),
        .lo         (seq_lo)
    );

    always_comb begin
        acc_addr = {seq_hi, seq_lo};
        mem_we   = (acc && dec_wr) ? dec_mask : '0;
    end

    always_comb begin
        st_d           = st_q;
        st_d.rd_valid  = acc && !dec_wr;
        st_d.out_valid = st_q.rd_valid;
        if (cyc == CYC_DESEL) st_d.active = 1'b0;
        if (acc) begin
            st_d.active  = 1'b1;
            st_d.beat    = seq_beat;
            st_d.base    = seq_base;
            st_d.hi      = seq_hi;
            st_d.rd_addr = acc_addr;
        end
        if (st_q.rd_valid) st_d.data = mem[st_q.rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (mem_we[i]) mem[acc_addr][i*LANE_W +: LANE_W] <= dq_in[i*LANE_W +: LANE_W];
        end
    end

    assign dq_out   = st_q.data;
    assign dq_drive = st_q.out_valid && !oe_n && !sleep;

    a_r1_no_burst_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && (cyc == CYC_STEP || cyc == CYC_WAIT)) |=> !st_q.rd_valid);
    a_r1_no_burst_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && (cyc == CYC_STEP || cyc == CYC_WAIT)) |-> (mem_we == '0));
    a_r2_desel_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_DESEL) |=> !st_q.active);
    a_r2_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_DESEL) |=> ##1 !st_q.out_valid);
    a_r4_proc_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !cs1_n && !strb_proc_n) |-> (mem_we == '0));
    a_r6_step_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_STEP && st_q.active) |=> (st_q.beat == $past(st_q.beat) + 1'b1));
    a_r7_wait_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_WAIT && st_q.active) |=> $stable(st_q.beat));
    a_r8_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && strb_proc_n && !strb_ctl_n && !cs1_n && cs2 && !cs3_n && !wr_all_n)
        |-> (&mem_we));
    a_r11_sleep_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (mem_we == '0));
    a_r11_sleep_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !st_q.rd_valid);
endmodule

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
    localparam int AW = 6;
    localparam int DW = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr;
    logic cs1_n, cs2, cs3_n, strb_proc_n, strb_ctl_n, step_n;
    logic wr_all_n, wr_lane_en_n, oe_n, sleep, order_sel;
    logic [1:0] lane_wr_n;
    logic [DW-1:0] dq_in, dq_out;
    logic dq_drive;

    logic [DW-1:0] ref_mem [64];
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sync_burst_sram u_sync_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .strb_proc_n(strb_proc_n), .strb_ctl_n(strb_ctl_n), .step_n(step_n),
        .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .lane_wr_n(lane_wr_n),
        .oe_n(oe_n), .sleep(sleep), .order_sel(order_sel), .dq_in(dq_in),
        .dq_out(dq_out), .dq_drive(dq_drive)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic no_write();
        wr_all_n = 1'b1; wr_lane_en_n = 1'b1; lane_wr_n = 2'b11;
    endtask

    task automatic drv_idle();
        cs1_n = 1'b1; cs2 = 1'b1; cs3_n = 1'b0;
        strb_proc_n = 1'b1; strb_ctl_n = 1'b0; step_n = 1'b1;
        no_write();
    endtask

    task automatic drv_proc(input logic [AW-1:0] a);
        cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
        strb_proc_n = 1'b0; strb_ctl_n = 1'b1; step_n = 1'b1; addr = a;
    endtask

    task automatic drv_ctl(input logic [AW-1:0] a);
        cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
        strb_proc_n = 1'b1; strb_ctl_n = 1'b0; step_n = 1'b1; addr = a;
    endtask

    task automatic drv_cont(input logic adv);
        strb_proc_n = 1'b1; strb_ctl_n = 1'b1; step_n = !adv;
    endtask

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] a, input int i, input logic m);
        logic [1:0] lo;
        lo = m ? (a[1:0] ^ 2'(i)) : (a[1:0] + 2'(i));
        return {a[AW-1:2], lo};
    endfunction

    task automatic write_burst(input logic [AW-1:0] a, input logic m, input logic [DW-1:0] seed);
        order_sel = m;
        for (int i = 0; i < 4; i++) begin
            if (i == 0) drv_ctl(a); else drv_cont(1'b1);
            wr_all_n = 1'b0;
            dq_in = seed + DW'(i * 18'h01111);
            ref_mem[beat_addr(a, i, m)] = dq_in;
            tick();
        end
        drv_idle();
    endtask

    task automatic read_chk(input logic [AW-1:0] a, input logic m, input int n, input string tag);
        order_sel = m;
        for (int i = 0; i < n; i++) begin
            if (i == 0) drv_proc(a); else drv_cont(1'b1);
            no_write();
            tick();
            if (i > 0) check(tag, {13'd0, dq_drive, dq_out}, {13'd0, 1'b1, ref_mem[beat_addr(a, i - 1, m)]});
        end
        drv_idle();
        tick();
        check(tag, {13'd0, dq_drive, dq_out}, {13'd0, 1'b1, ref_mem[beat_addr(a, n - 1, m)]});
    endtask

    task automatic t_reset();
        check("R1 reset drive", {31'd0, dq_drive}, 32'd0);
        drv_idle(); cs1_n = 1'b0; drv_cont(1'b1); wr_all_n = 1'b0; dq_in = '0;
        tick();
        drv_idle(); tick();
        check("R1 continue without burst", {31'd0, dq_drive}, 32'd0);
    endtask

    task automatic t_linear();
        write_burst(6'h0A, 1'b0, 18'h10203);
        read_chk(6'h0A, 1'b0, 4, "R6 R5 R9 R12 linear");
        read_chk(6'h08, 1'b0, 4, "R6 linear from 0");
    endtask

    task automatic t_interleave();
        write_burst(6'h15, 1'b1, 18'h2A5A5);
        read_chk(6'h15, 1'b1, 4, "R6 interleaved");
        read_chk(6'h16, 1'b1, 4, "R6 interleaved base 2");
    endtask

    task automatic t_lanes();
        drv_ctl(6'h08); wr_all_n = 1'b1; wr_lane_en_n = 1'b0; lane_wr_n = 2'b10;
        dq_in = 18'h3FFFF;
        ref_mem[6'h08][8:0] = 9'h1FF;
        tick(); drv_idle();
        read_chk(6'h08, 1'b0, 1, "R8 lane 0 only");
        drv_ctl(6'h08); wr_lane_en_n = 1'b0; lane_wr_n = 2'b11; dq_in = '0;
        tick();
        drv_idle(); tick();
        check("R8 lane enable without lanes reads", {13'd0, dq_drive, dq_out}, {13'd0, 1'b1, ref_mem[6'h08]});
        drv_ctl(6'h09); wr_lane_en_n = 1'b0; lane_wr_n = 2'b01; dq_in = 18'h00000;
        ref_mem[6'h09][17:9] = 9'h000;
        tick(); drv_idle();
        read_chk(6'h09, 1'b0, 1, "R8 lane 1 only");
    endtask

    task automatic t_proc_wins();
        drv_proc(6'h0B); wr_all_n = 1'b0; dq_in = 18'h00000;
        tick();
        drv_idle(); tick();
        check("R4 processor strobe reads", {13'd0, dq_drive, dq_out}, {13'd0, 1'b1, ref_mem[6'h0B]});
        read_chk(6'h0B, 1'b0, 1, "R4 memory unchanged");
    endtask

    task automatic t_wait();
        order_sel = 1'b0;
        drv_ctl(6'h20); wr_all_n = 1'b0; dq_in = 18'h11111; tick();
        drv_cont(1'b0); wr_all_n = 1'b0; dq_in = 18'h22222; tick();
        drv_cont(1'b1); wr_all_n = 1'b0; dq_in = 18'h33333; tick();
        ref_mem[6'h20] = 18'h22222; ref_mem[6'h21] = 18'h33333;
        drv_idle(); tick();
        drv_proc(6'h20); no_write(); tick();
        drv_cont(1'b0); tick();
        check("R7 wait beat a", {13'd0, dq_drive, dq_out}, {13'd0, 1'b1, ref_mem[6'h20]});
        drv_cont(1'b1); tick();
        check("R7 wait beat b", {13'd0, dq_drive, dq_out}, {13'd0, 1'b1, ref_mem[6'h20]});
        drv_idle(); tick();
        check("R7 after wait steps", {13'd0, dq_drive, dq_out}, {13'd0, 1'b1, ref_mem[6'h21]});
    endtask

    task automatic t_desel();
        order_sel = 1'b0;
        drv_proc(6'h20); no_write(); tick();
        drv_proc(6'h21); cs2 = 1'b0; tick();
        check("R2 prior read still out", {13'd0, dq_drive, dq_out}, {13'd0, 1'b1, ref_mem[6'h20]});
        drv_cont(1'b1); cs2 = 1'b1; tick();
        check("R2 deselect quiet", {31'd0, dq_drive}, 32'd0);
        tick();
        check("R2 burst ended", {31'd0, dq_drive}, 32'd0);
        drv_proc(6'h20); tick();
        drv_proc(6'h21); cs3_n = 1'b1; tick();
        drv_idle(); tick();
        check("R2 cs3 deselect", {31'd0, dq_drive}, 32'd0);
    endtask

    task automatic t_cs1_high();
        order_sel = 1'b0;
        drv_proc(6'h20); no_write(); tick();
        cs1_n = 1'b1; strb_proc_n = 1'b0; strb_ctl_n = 1'b1; step_n = 1'b0; addr = 6'h0A; tick();
        drv_idle(); tick();
        check("R3 proc strobe ignored continues", {13'd0, dq_drive, dq_out}, {13'd0, 1'b1, ref_mem[6'h21]});
    endtask

    task automatic t_oe();
        drv_proc(6'h21); no_write(); tick();
        drv_idle(); tick();
        oe_n = 1'b1; #0.5;
        check("R10 oe high stops drive", {31'd0, dq_drive}, 32'd0);
        oe_n = 1'b0; #0.5;
        check("R10 oe low drives", {31'd0, dq_drive}, 32'd1);
        tick();
    endtask

    task automatic t_sleep();
        drv_proc(6'h21); no_write(); tick();
        drv_idle(); tick();
        sleep = 1'b1; #0.5;
        check("R11 sleep stops drive", {31'd0, dq_drive}, 32'd0);
        drv_ctl(6'h21); wr_all_n = 1'b0; dq_in = 18'h00000;
        tick();
        sleep = 1'b0; drv_idle(); tick();
        read_chk(6'h21, 1'b0, 1, "R11 no write in sleep");
    endtask

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        addr = '0; dq_in = '0; oe_n = 1'b0; sleep = 1'b0; order_sel = 1'b0;
        drv_idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        t_reset();
        t_linear();
        t_interleave();
        t_lanes();
        t_proc_wins();
        t_wait();
        t_desel();
        t_cs1_high();
        t_oe();
        t_sleep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule